// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the line and field timing for an analogue video raster whose every interval is set at run time. Software, or a front panel controller, writes the horizontal intervals as counts of pixel clocks: sync pulse, back porch, active picture and front porch. It also writes the vertical layout: blanking lines per field, active lines per field, and the number of half-line broad pulses that form the field sync. A single mode bit chooses progressive or interlaced scanning. The intended frame rate is 25 Hz. The programmer reaches it by picking totals that divide the pixel clock. The block does not enforce the rate.

The outputs are an active-low composite sync, horizontal and vertical blanking, a video enable, a field identifier, and the pixel and line indices that a framestore read port uses to fetch the picture. In progressive mode both fields of a frame carry the same line numbering, so the read side repeats one stored field on both. In interlaced mode each field is half a line longer, and the second field begins at mid-line. A build-time sync depth is presented to the external DAC whenever sync is low.

All settings are sampled at reset and at each frame boundary, so a frame in progress never mixes two settings.

Top module: `raster_timing_gen`

## Requirements
- R1: A line lasts sync + back porch + active + front porch clocks, with sync first. hBlank is low only for the active window, which starts sync + back porch clocks into the line. The line length must be even, and the sync width must be at least 1.
- R2: Outside the broad-pulse interval, csyncN is low for exactly the first sync-width clocks of each line and high for the rest of the line.
- R3: Each field opens with a broad-pulse interval lasting the programmed number of half-lines, where a half-line is half the line length. In every half-line of that interval, csyncN is low for the first (half-line − sync width) clocks and high for the remaining sync-width clocks.
- R4: Within a field, the first blanking-count lines have vBlank high, the next active-count lines have vBlank low, and any further line has vBlank high. The line count restarts at the start of each field. The blanking count must be at least 1.
- R5: In progressive mode a field is exactly blanking + active lines long and starts at a line start. fieldId alternates 0, 1 from field to field, and both fields give the same line indices.
- R6: In interlaced mode each field is one half-line longer than in progressive mode. Field 1 begins at mid-line, and its first full line is line 1 of the field.
- R7: videoEn is high exactly when both blanks are low. During videoEn, pixelIdx counts from 0 across the active window and lineIdx is the active line number counting from 0. When videoEn is low, pixelIdx is 0.
- R8: Configuration inputs take effect only at reset and at the first clock of field 0. A change during a frame leaves the rest of that frame unchanged.
- R9: While reset is held, the raster sits at the first clock of field 0: fieldId is 0, videoEn is 0 and both indices are 0.
- R10: syncLevel equals the SYNC_LEVEL parameter whenever csyncN is low, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high; samples the configuration |
| cfgActiveLines | input | V_W | Active lines per field |
| cfgBlankLines | input | V_W | Blanking lines at the top of each field |
| cfgBroadHalves | input | V_W | Broad pulses per field, counted in half-lines |
| cfgSyncWidth | input | H_W | Line sync width in clocks |
| cfgBackPorch | input | H_W | Back porch in clocks |
| cfgActivePixels | input | H_W | Active picture width in clocks |
| cfgFrontPorch | input | H_W | Front porch in clocks |
| cfgInterlace | input | 1 | 1 for interlaced scanning, 0 for progressive |
| csyncN | output | 1 | Composite sync, active low |
| hBlank | output | 1 | Horizontal blanking |
| vBlank | output | 1 | Vertical blanking |
| videoEn | output | 1 | Active picture enable |
| fieldId | output | 1 | Current field, 0 or 1 |
| pixelIdx | output | H_W | Pixel index within the active window |
| lineIdx | output | V_W | Active line index within the field |
| syncLevel | output | LEVEL_W | Sync depth code for the DAC |

## Verification
The bench targets the half-line seam of interlaced mode. A design that started field 1 on a line boundary, or counted its first half-line as a full line, would move the field change and shift every active line of field 1 by one. Within the broad pulses it probes the clock where the pulse ends in each half-line. Confusing the broad pulse with a normal sync would leave csyncN high there, or low there, by mistake. It changes the sync and porch widths mid-frame and checks that the old pulse width holds until field 0 restarts. It also confirms that the second progressive field reproduces the line indices of the first instead of continuing them.

// File: rtl/raster_timing_pkg.sv
package raster_timing_pkg;
  typedef struct packed {
    logic broad;      // inside the broad-pulse half-lines
    logic vActive;    // current line is a picture line
    logic frameWrap;  // last clock of the frame
  } tgStrobe_t;
endpackage

// File: rtl/raster_timing_horiz.sv
module raster_timing_horiz
  import raster_timing_pkg::*;
#(
  parameter int H_W = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [H_W-1:0] syncW,
  input  logic [H_W-1:0] backW,
  input  logic [H_W-1:0] actW,
  input  logic [H_W-1:0] frontW,
  input  tgStrobe_t      strobe,
  output logic           halfEnd,
  output logic           lineEnd,
  output logic           hBlank,
  output logic           csyncN,
  output logic           videoEn,
  output logic [H_W-1:0] pixel
);
  localparam int HC_W = H_W + 2;
  localparam logic [HC_W-1:0] ONE_H = 1;

  logic [HC_W-1:0] hCount, lineLen, halfLen, actStart, actEnd, halfPos, broadLow;
  logic            inAct;

  assign lineLen  = {2'b00, syncW} + {2'b00, backW} + {2'b00, actW} + {2'b00, frontW};
  assign halfLen  = lineLen >> 1;
  assign actStart = {2'b00, syncW} + {2'b00, backW};
  assign actEnd   = actStart + {2'b00, actW};

  assign lineEnd = (hCount == lineLen - ONE_H);
  assign halfEnd = lineEnd || (hCount == halfLen - ONE_H);

  always_ff @(posedge clk) begin
    if (rst || lineEnd || strobe.frameWrap) hCount <= '0;
    else                                    hCount <= hCount + ONE_H;
  end

  assign halfPos  = (hCount >= halfLen) ? hCount - halfLen : hCount;
  assign broadLow = halfLen - {2'b00, syncW};

  always_comb begin
    inAct   = (hCount >= actStart) && (hCount < actEnd);
    hBlank  = !inAct;
    videoEn = inAct && strobe.vActive;
    pixel   = videoEn ? H_W'(hCount - actStart) : '0;
    if (strobe.broad) csyncN = !(halfPos < broadLow);
    else              csyncN = !(hCount < {2'b00, syncW});
  end
endmodule

// File: rtl/raster_timing_vert.sv
module raster_timing_vert
  import raster_timing_pkg::*;
#(
  parameter int V_W = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [V_W-1:0] activeL,
  input  logic [V_W-1:0] blankL,
  input  logic [V_W-1:0] broadH,
  input  logic           interlace,
  input  logic           halfEnd,
  input  logic           lineEnd,
  output tgStrobe_t      strobe,
  output logic           field,
  output logic [V_W-1:0] lineOut
);
  localparam int HV_W = V_W + 2;
  localparam int LV_W = V_W + 1;
  localparam logic [HV_W-1:0] ONE_HV = 1;
  localparam logic [LV_W-1:0] ONE_LV = 1;

  logic [HV_W-1:0] halfIdx, fieldHalves;
  logic [LV_W-1:0] lineCnt, fieldLines;
  logic            fieldEnd;

  assign fieldLines  = {1'b0, activeL} + {1'b0, blankL};
  assign fieldHalves = {fieldLines, 1'b0} + {{LV_W{1'b0}}, interlace};
  assign fieldEnd    = halfEnd && (halfIdx == fieldHalves - ONE_HV);

  always_ff @(posedge clk) begin
    if (rst) begin
      halfIdx <= '0;
      lineCnt <= '0;
      field   <= 1'b0;
    end else if (halfEnd) begin
      if (fieldEnd) begin
        halfIdx <= '0;
        lineCnt <= '0;
        field   <= !field;
      end else begin
        halfIdx <= halfIdx + ONE_HV;
        if (lineEnd) lineCnt <= lineCnt + ONE_LV;
      end
    end
  end

  always_comb begin
    strobe.frameWrap = fieldEnd && field;
    strobe.broad     = halfIdx < {2'b00, broadH};
    strobe.vActive   = (lineCnt >= {1'b0, blankL}) && (lineCnt < fieldLines);
    lineOut          = strobe.vActive ? V_W'(lineCnt - {1'b0, blankL}) : '0;
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_timing_pkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 10,
  parameter int LEVEL_W = 8,
  parameter logic [LEVEL_W-1:0] SYNC_LEVEL = 77
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [V_W-1:0]     cfgActiveLines,
  input  logic [V_W-1:0]     cfgBlankLines,
  input  logic [V_W-1:0]     cfgBroadHalves,
  input  logic [H_W-1:0]     cfgSyncWidth,
  input  logic [H_W-1:0]     cfgBackPorch,
  input  logic [H_W-1:0]     cfgActivePixels,
  input  logic [H_W-1:0]     cfgFrontPorch,
  input  logic               cfgInterlace,
  output logic               csyncN,
  output logic               hBlank,
  output logic               vBlank,
  output logic               videoEn,
  output logic               fieldId,
  output logic [H_W-1:0]     pixelIdx,
  output logic [V_W-1:0]     lineIdx,
  output logic [LEVEL_W-1:0] syncLevel
);
  tgStrobe_t      strobe;
  logic           halfEnd, lineEnd;
  logic [V_W-1:0] activeL, blankL, broadH;
  logic [H_W-1:0] syncW, backW, actW, frontW;
  logic           interlace;

  // settings change only at reset or when a new frame begins
  always_ff @(posedge clk) begin
    if (rst || strobe.frameWrap) begin
      activeL   <= cfgActiveLines;
      blankL    <= cfgBlankLines;
      broadH    <= cfgBroadHalves;
      syncW     <= cfgSyncWidth;
      backW     <= cfgBackPorch;
      actW      <= cfgActivePixels;
      frontW    <= cfgFrontPorch;
      interlace <= cfgInterlace;
    end
  end

  raster_timing_horiz #(.H_W(H_W)) uHoriz (
    .clk(clk), .rst(rst), .syncW(syncW), .backW(backW), .actW(actW), .frontW(frontW),
    .strobe(strobe), .halfEnd(halfEnd), .lineEnd(lineEnd), .hBlank(hBlank),
    .csyncN(csyncN), .videoEn(videoEn), .pixel(pixelIdx)
  );

  raster_timing_vert #(.V_W(V_W)) uVert (
    .clk(clk), .rst(rst), .activeL(activeL), .blankL(blankL), .broadH(broadH),
    .interlace(interlace), .halfEnd(halfEnd), .lineEnd(lineEnd),
    .strobe(strobe), .field(fieldId), .lineOut(lineIdx)
  );

  assign vBlank    = !strobe.vActive;
  assign syncLevel = csyncN ? '0 : SYNC_LEVEL;
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int H_W = 12,
  parameter int V_W = 10
) (
  input logic           clk,
  input logic           rst,
  input logic           csyncN,
  input logic           vBlank,
  input logic           videoEn,
  input logic           fieldId,
  input logic [H_W-1:0] pixelIdx,
  input logic [V_W-1:0] lineIdx
);
  localparam logic [H_W-1:0] ONE_P = 1;

  assert_no_sync_in_active_R2: assert property (@(posedge clk) disable iff (rst)
    videoEn |-> csyncN);

  assert_pixel_zero_blank_R7: assert property (@(posedge clk) disable iff (rst)
    !videoEn |-> (pixelIdx == '0));

  assert_pixel_step_R1: assert property (@(posedge clk) disable iff (rst)
    (videoEn && $past(videoEn)) |-> (pixelIdx == $past(pixelIdx) + ONE_P));

  assert_line_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (videoEn && $past(videoEn)) |-> (lineIdx == $past(lineIdx)));

  assert_field_in_blank_R5: assert property (@(posedge clk) disable iff (rst)
    (fieldId != $past(fieldId)) |-> vBlank);
endmodule

bind raster_timing_gen raster_timing_chk #(.H_W(H_W), .V_W(V_W)) uChk (.*);

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;
  localparam int H_W = 12;
  localparam int V_W = 10;
  localparam int LEVEL_W = 8;
  localparam logic [LEVEL_W-1:0] LVL = 77;

  // phase, cycle, csyncN, hBlank, vBlank, videoEn, fieldId, pixelIdx, lineIdx
  typedef struct packed {
    logic [1:0] ph;
    logic [7:0] t;
    logic cs, hb, vb, de, fld;
    logic [3:0] pix, ln;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'd0,   1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0},
    '{2'd0, 8'd3,   1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0},
    '{2'd0, 8'd5,   1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0},
    '{2'd0, 8'd20,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
    '{2'd0, 8'd25,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1, 4'd0},
    '{2'd0, 8'd47,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3, 4'd2},
    '{2'd0, 8'd48,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 4'd2},
    '{2'd0, 8'd50,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0},
    '{2'd0, 8'd75,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1, 4'd0},
    '{2'd0, 8'd97,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3, 4'd2},
    '{2'd0, 8'd100, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0},
    '{2'd1, 8'd50,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0},
    '{2'd1, 8'd52,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0},
    '{2'd1, 8'd54,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0},
    '{2'd1, 8'd55,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0},
    '{2'd1, 8'd58,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0},
    '{2'd1, 8'd60,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0},
    '{2'd1, 8'd75,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1, 4'd0},
    '{2'd1, 8'd97,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3, 4'd2},
    '{2'd1, 8'd105, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0},
    '{2'd1, 8'd110, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0},
    '{2'd1, 8'd135, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1, 4'd0},
    '{2'd2, 8'd22,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
    '{2'd2, 8'd62,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0},
    '{2'd2, 8'd72,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0},
    '{2'd2, 8'd120, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
    '{2'd2, 8'd122, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
    '{2'd2, 8'd123, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
    '{2'd2, 8'd124, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 4'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [V_W-1:0] cfgActiveLines, cfgBlankLines, cfgBroadHalves;
  logic [H_W-1:0] cfgSyncWidth, cfgBackPorch, cfgActivePixels, cfgFrontPorch;
  logic cfgInterlace;
  logic csyncN, hBlank, vBlank, videoEn, fieldId;
  logic [H_W-1:0] pixelIdx;
  logic [V_W-1:0] lineIdx;
  logic [LEVEL_W-1:0] syncLevel;

  int checks = 0;
  int errors = 0;

  always #5 clk = !clk;

  raster_timing_gen #(.H_W(H_W), .V_W(V_W), .LEVEL_W(LEVEL_W), .SYNC_LEVEL(LVL)) dut (
    .clk(clk), .rst(rst),
    .cfgActiveLines(cfgActiveLines), .cfgBlankLines(cfgBlankLines),
    .cfgBroadHalves(cfgBroadHalves), .cfgSyncWidth(cfgSyncWidth),
    .cfgBackPorch(cfgBackPorch), .cfgActivePixels(cfgActivePixels),
    .cfgFrontPorch(cfgFrontPorch), .cfgInterlace(cfgInterlace),
    .csyncN(csyncN), .hBlank(hBlank), .vBlank(vBlank), .videoEn(videoEn),
    .fieldId(fieldId), .pixelIdx(pixelIdx), .lineIdx(lineIdx), .syncLevel(syncLevel)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // line 10 clocks: sync 2, back porch 2, active 4, front porch 2; 2 blank + 3 active lines
  task automatic setConfig(input logic ilace);
    cfgSyncWidth = 12'd2; cfgBackPorch = 12'd2; cfgActivePixels = 12'd4; cfgFrontPorch = 12'd2;
    cfgBlankLines = 10'd2; cfgActiveLines = 10'd3; cfgBroadHalves = 10'd2;
    cfgInterlace = ilace;
  endtask

  task automatic checkVec(input vec_t v);
    string tag;
    tag = (v.ph == 2'd0) ? "R5" : (v.ph == 2'd1) ? "R6" : "R8";
    check({tag, " R2/R3"}, $sformatf("csyncN t=%0d", v.t), int'(csyncN), int'(v.cs));
    check({tag, " R1"}, $sformatf("hBlank t=%0d", v.t), int'(hBlank), int'(v.hb));
    check({tag, " R4"}, $sformatf("vBlank t=%0d", v.t), int'(vBlank), int'(v.vb));
    check({tag, " R7"}, $sformatf("videoEn t=%0d", v.t), int'(videoEn), int'(v.de));
    check({tag, " field"}, $sformatf("fieldId t=%0d", v.t), int'(fieldId), int'(v.fld));
    check({tag, " R7"}, $sformatf("pixelIdx t=%0d", v.t), int'(pixelIdx), int'(v.de ? v.pix : 4'd0));
    if (v.de) check({tag, " R7"}, $sformatf("lineIdx t=%0d", v.t), int'(lineIdx), int'(v.ln));
    check({tag, " R10"}, $sformatf("syncLevel t=%0d", v.t), int'(syncLevel), v.cs ? 0 : int'(LVL));
  endtask

  initial begin
    setConfig(1'b0);
    for (int ph = 0; ph < 3; ph++) begin
      setConfig(ph == 1);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      // R9: state while reset is held
      check("R9", "fieldId in reset", int'(fieldId), 0);
      check("R9", "videoEn in reset", int'(videoEn), 0);
      check("R9", "pixelIdx in reset", int'(pixelIdx), 0);
      check("R9", "lineIdx in reset", int'(lineIdx), 0);
      rst = 1'b0;
      for (int t = 0; t < 140; t++) begin
        for (int i = 0; i < NV; i++)
          if (int'(VEC[i].ph) == ph && int'(VEC[i].t) == t) checkVec(VEC[i]);
        if (ph == 2 && t == 20) begin
          // R8: new widths keep the line length and active start
          cfgSyncWidth = 12'd3;
          cfgBackPorch = 12'd1;
        end
        @(negedge clk);
      end
    end
    // R9: reset in mid-field returns to field 0, first clock
    setConfig(1'b0);
    rst = 1'b0;
    repeat (57) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9", "fieldId after mid reset", int'(fieldId), 0);
    check("R9", "csyncN after mid reset", int'(csyncN), 0);
    check("R9", "vBlank after mid reset", int'(vBlank), 1);
    rst = 1'b0;
    repeat (25) @(negedge clk);
    check("R9", "videoEn 25 clocks after reset", int'(videoEn), 1);
    check("R9", "pixelIdx 25 clocks after reset", int'(pixelIdx), 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule